// File: doc/BRIEF.md
# Interval Timer with Limit Match and Sticky Match Flag

This block is a memory-mapped up-counter for periodic interrupts. A prescaler divides the system clock into fixed ticks, and each tick advances a count. The count is held in units of ticks and is presented in the read word starting at bit 9. When the next count would reach the programmed limit, the count returns to zero on that tick. At the same moment a sticky match flag is set, and this flag drives the interrupt output. With the default prescale of 125 at a 250 MHz clock, one tick lasts 500 ns.

Software programs the limit in one of two ways. A write to the restarting limit word also zeroes the count, the prescaler phase and the flag. A write to the keeping limit word changes only the limit. A limit of zero means free-running: the count wraps at its largest value and still raises the flag. Software acknowledges the interrupt by reading the limit word. Read data comes out of a register one cycle after the read strobe.

Top module: `lim_timer`

## Requirements
- R1: After reset the limit, count, flag, interrupt and read data are all zero, and the count starts advancing without any write.
- R2: The count field sits at read bits [9+CNT_W-1:9] and goes up by one on every tick. A tick occurs once every TICK_DIV clock cycles. Bits 8:0 of the read word are always zero, and so are the bits between the field and bit 31.
- R3: On a tick where count+1 is greater than or equal to the effective limit, the count becomes zero and the flag is set in the same cycle. The irq output always equals the flag.
- R4: A read of byte offset 0x0 returns the limit in the count field position with bit 31 zero. The read clears the flag and irq after that edge. If a wrap occurs in the same cycle, setting the flag wins.
- R5: A write to offset 0x0 stores wdata[9+CNT_W-1:9] as the limit and discards the other bits. The same write zeroes the count, the flag and the prescaler, so the flag rises exactly limit×TICK_DIV cycles after the write edge.
- R6: A write to offset 0x8 stores the limit in the same way but leaves the count, the flag and the prescaler untouched. If the new limit is at or below count+1, the next tick wraps.
- R7: A limit of zero selects free-run mode. The count then wraps after 2^CNT_W−1 ticks and sets the flag as it does so.
- R8: A read of offset 0x4 returns the count in the field position, with the flag in bit 31.
- R9: Offsets 0xC and above read as zero, and writes to them change nothing. Address bits 1:0 are ignored.
- R10: Read data is updated only at an edge where rd_en is high, and is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Byte offset of the accessed word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, high while the match flag is set |

## Verification
The bench first runs directed sequences. A restarting write is followed by an exact count of cycles to the flag, which separates an off-by-one tick or a missed prescaler restart from correct timing. A keeping write that lowers the limit below the running count shows that the count is preserved and that the `>=` compare wraps it. A zero limit is followed by a full free-run period, and the ignored upper offset is probed after a nonzero limit is programmed so that a stray write would be visible. A seeded random mix of reads and writes then exercises every offset with junk in the unused data and low address bits. This mix catches collisions between ticks, acknowledges and writes, and each read word is compared with a requirement-level model.

// File: rtl/lt_pkg.sv
package lt_pkg;

    // Bit position of the tick-granular count inside the 32-bit word
    localparam int unsigned CNT_LSB = 9;

    typedef enum logic [1:0] {
        WSEL_LIMIT      = 2'd0,   // offset 0x0: limit, restart on write
        WSEL_COUNT      = 2'd1,   // offset 0x4: count and flag
        WSEL_LIMIT_KEEP = 2'd2,   // offset 0x8: limit, count kept
        WSEL_NONE       = 2'd3    // everything else
    } wsel_e;

    function automatic wsel_e word_sel(input int unsigned widx);
        case (widx)
            0:       return WSEL_LIMIT;
            1:       return WSEL_COUNT;
            2:       return WSEL_LIMIT_KEEP;
            default: return WSEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lt_tick_gen.sv
module lt_tick_gen #(
    parameter int unsigned DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_st_t;

    tick_st_t q, d;

    always_comb begin
        d = q;
        if (clr_i || q.cnt == LAST) d.cnt = '0;
        else                        d.cnt = q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = (q.cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o) else $error("tick on consecutive cycles"); // R2
        end
    endgenerate

endmodule

// File: rtl/lt_core.sv
module lt_core #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             lim_wr_i,
    input  logic             soft_wr_i,
    input  logic             lim_rd_i,
    input  logic [CNT_W-1:0] wval_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lim_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             flag;
    } core_st_t;

    core_st_t         q, d;
    logic [CNT_W-1:0] eff_lim;
    logic [CNT_W:0]   inc;
    logic             wrap;

    always_comb begin
        eff_lim = (q.lim == '0) ? CNT_MAX : q.lim;
        inc     = {1'b0, q.cnt} + (CNT_W+1)'(1);
        wrap    = tick_i && (inc >= {1'b0, eff_lim});

        d = q;
        if (lim_rd_i) d.flag = 1'b0;
        if (tick_i) begin
            if (wrap) begin
                d.cnt  = '0;
                d.flag = 1'b1;
            end else begin
                d.cnt  = inc[CNT_W-1:0];
            end
        end
        if (soft_wr_i) d.lim = wval_i;
        if (lim_wr_i) begin
            d.lim  = wval_i;
            d.cnt  = '0;
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o  = q.cnt;
    assign lim_o  = q.lim;
    assign flag_o = q.flag;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !lim_wr_i |=> (q.cnt == $past(q.cnt) + CNT_W'(1)) || (q.cnt == '0))
        else $error("count skipped"); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !lim_wr_i |=> $stable(q.cnt)) else $error("count moved without tick"); // R2
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !lim_wr_i |=> (q.cnt != '0) || q.flag) else $error("wrap without flag"); // R3
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        lim_rd_i && !tick_i |=> !q.flag) else $error("ack left flag set"); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        lim_wr_i |=> (q.cnt == '0) && !q.flag) else $error("restart incomplete"); // R5
    AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        soft_wr_i && !lim_wr_i && !lim_rd_i |=> q.flag || !$past(q.flag))
        else $error("keep write dropped flag"); // R6
    AST_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt != CNT_MAX) else $error("count reached wrap value"); // R7

endmodule

// File: rtl/lt_regif.sv
module lt_regif #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  lim_i,
    input  logic              flag_i,
    output logic              lim_wr_o,
    output logic              soft_wr_o,
    output logic              lim_rd_o,
    output logic [CNT_W-1:0]  wval_o,
    output logic [DATA_W-1:0] rdata_o
);
    import lt_pkg::*;

    localparam int unsigned FLD_HI = CNT_LSB + CNT_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rif_st_t;

    rif_st_t q, d;
    wsel_e   sel;
    logic    unused_bits;

    assign sel         = word_sel(32'(addr_i[ADDR_W-1:2]));
    assign lim_wr_o    = wr_en_i && (sel == WSEL_LIMIT);
    assign soft_wr_o   = wr_en_i && (sel == WSEL_LIMIT_KEEP);
    assign lim_rd_o    = rd_en_i && (sel == WSEL_LIMIT);
    assign wval_o      = wdata_i[CNT_LSB +: CNT_W];
    assign unused_bits = ^{wdata_i[CNT_LSB-1:0], wdata_i[DATA_W-1:FLD_HI], addr_i[1:0]};

    always_comb begin
        d = q;
        if (rd_en_i) begin
            d.rdata = '0;
            case (sel)
                WSEL_LIMIT: d.rdata[CNT_LSB +: CNT_W] = lim_i;
                WSEL_COUNT: begin
                    d.rdata[CNT_LSB +: CNT_W] = cnt_i;
                    d.rdata[DATA_W-1]         = flag_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata_o = q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)) else $error("read data changed idle"); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (sel == WSEL_NONE) |=> rdata_o == '0) else $error("unmapped read nonzero"); // R9

endmodule

// File: rtl/lim_timer.sv
module lim_timer #(
    parameter int unsigned TICK_DIV = 125,
    parameter int unsigned CNT_W    = 22,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic             tick;
    logic             lim_wr;
    logic             soft_wr;
    logic             lim_rd;
    logic [CNT_W-1:0] wval;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             flag;

    lt_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (lim_wr),
        .tick_o (tick)
    );

    lt_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .lim_wr_i  (lim_wr),
        .soft_wr_i (soft_wr),
        .lim_rd_i  (lim_rd),
        .wval_i    (wval),
        .cnt_o     (cnt),
        .lim_o     (lim),
        .flag_o    (flag)
    );

    lt_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .cnt_i     (cnt),
        .lim_i     (lim),
        .flag_i    (flag),
        .lim_wr_o  (lim_wr),
        .soft_wr_o (soft_wr),
        .lim_rd_o  (lim_rd),
        .wval_o    (wval),
        .rdata_o   (rdata)
    );

    assign irq = flag;

endmodule

// File: tb/test_lim_timer.sv
module test_lim_timer;

    localparam int unsigned DIV   = 3;
    localparam int unsigned CW    = 5;
    localparam int unsigned LSB   = 9;
    localparam int unsigned MAXU  = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lim_timer #(.TICK_DIV(DIV), .CNT_W(CW), .ADDR_W(4), .DATA_W(32)) i_lim_timer (
        .clk, .rst_n, .rd_en, .wr_en, .addr, .wdata, .rdata, .irq
    );

    // requirement-level model
    int unsigned m_presc, m_cnt, m_lim;
    logic        m_flag;
    logic [31:0] m_rdata;
    int unsigned m_last;

    function automatic logic [31:0] exp_word(int unsigned w, int unsigned lim,
                                             int unsigned cnt, logic flag);
        logic [31:0] r = '0;
        if (w == 0) r = 32'(lim) << LSB;
        else if (w == 1) r = (32'(cnt) << LSB) | {flag, 31'd0};
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_presc <= 0; m_cnt <= 0; m_lim <= 0; m_flag <= 1'b0;
            m_rdata <= '0; m_last <= 0;
        end else begin : mdl
            int unsigned w, nc, nl, eff;
            logic tk, nf;
            w  = addr[3:2];
            tk = (m_presc == DIV - 1);
            nc = m_cnt; nl = m_lim; nf = m_flag;
            if (rd_en && w == 0) nf = 1'b0;
            if (tk) begin
                eff = (m_lim == 0) ? MAXU : m_lim;
                if (m_cnt + 1 >= eff) begin nc = 0; nf = 1'b1; end
                else nc = m_cnt + 1;
            end
            if (wr_en && w == 2) nl = (wdata >> LSB) & MAXU;
            if (wr_en && w == 0) begin
                nl = (wdata >> LSB) & MAXU; nc = 0; nf = 1'b0;
            end
            m_presc <= (wr_en && w == 0) ? 0 : (tk ? 0 : m_presc + 1);
            if (rd_en) begin
                m_rdata <= exp_word(w, m_lim, m_cnt, m_flag);
                m_last  <= w;
            end
            m_cnt <= nc; m_lim <= nl; m_flag <= nf;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // continuous comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1 irq in reset", {31'd0, irq}, 32'd0);
                chk("R1 rdata in reset", rdata, 32'd0);
            end else begin
                chk("R3 irq equals flag", {31'd0, irq}, {31'd0, m_flag});
                case (m_last)
                    0:       chk("R4 limit word", rdata, m_rdata);
                    1:       chk("R8 count word", rdata, m_rdata);
                    default: chk("R9 unmapped word", rdata, m_rdata);
                endcase
            end
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = $urandom;
    endtask

    task automatic rd(logic [3:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        rd(4'h0);
        chk("R1 limit after reset", rdata, 32'd0);
        rd(4'h4);
        chk("R1 running after reset", {31'd0, rdata != 0}, 32'd1);

        // R5: restart write, junk outside the field
        wr(4'h0, 32'h8000_09FF);
        repeat (11) @(negedge clk);
        chk("R5 no flag before limit", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R3 flag at limit", {31'd0, irq}, 32'd1);
        rd(4'h4);
        chk("R8 count zero with flag", rdata, 32'h8000_0000);
        rd(4'h0);
        chk("R4 limit masked", rdata, 32'h0000_0800);
        chk("R4 irq acknowledged", {31'd0, irq}, 32'd0);

        // R6: keep write below running count
        repeat (7) @(negedge clk);
        wr(4'h8, 32'h0000_0400);
        rd(4'h4);
        chk("R6 count kept", rdata, 32'h0000_0600);
        @(negedge clk);
        chk("R6 next tick wraps", {31'd0, irq}, 32'd1);

        // R7: free run
        wr(4'h0, 32'h0000_0000);
        repeat (92) @(negedge clk);
        chk("R7 no flag before full span", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 flag at full span", {31'd0, irq}, 32'd1);
        rd(4'h0);
        chk("R7 limit reads zero", rdata, 32'd0);

        // R9: unmapped offset
        wr(4'h0, 32'h0000_0600);
        wr(4'hC, 32'h0000_3E00);
        rd(4'h1);
        chk("R9 low address bits ignored", rdata, 32'h0000_0600);
        rd(4'hC);
        chk("R9 unmapped read zero", rdata, 32'd0);

        // random mix (R2, R3, R4, R6, R10 via the model)
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 9);
            addr = {2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            if (r < 2) begin
                rd_en = 1'b1;
            end else if (r < 4) begin
                logic [31:0] v = $urandom;
                v[LSB +: CW] = 5'($urandom_range(0, 7));
                wdata = v;
                wr_en = 1'b1;
            end
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule